// File: doc/BRIEF.md
# Packed Vector Sign-Apply Unit

This unit takes a packed source vector and a packed control vector of equal width and, lane by lane, replaces each source lane with its two's-complement negation, with zero, or with itself. The choice comes from the matching control lane: negative selects negation, zero selects zero, and positive keeps the source. An 8-bit operation code picks the lane size at run time (bytes, 16-bit words or 32-bit doublewords), so the same vector can be split differently from one operation to the next.

The block is a single registered stage. An operation presented with `in_valid` lands in the result register on the next clock, and `out_valid` marks that cycle. With `in_reuse` set, the operand taken as the source is the current content of the result register rather than `src_a`. This gives the destructive two-operand form, in which the result overwrites its own source. With `in_reuse` low, the result goes to the result register and `src_a` is only read. An unknown operation code is flagged and never written.

Top module: `vec_sign_apply`

## Requirements
- R1: For a control lane whose most significant bit (at the current lane size) is 1, the result lane is the two's-complement negation of the source lane, modulo 2^lane-width.
- R2: For a control lane whose bits are all zero, the result lane is all zeros.
- R3: For a control lane that is nonzero with its most significant bit 0, the result lane equals the source lane.
- R4: `in_op` value 0x08 selects 8-bit lanes, 0x09 selects 16-bit lanes and 0x0A selects 32-bit lanes. The same rule applies to every lane across the full `VEC_W` bits.
- R5: The sign and zero tests use all bits of the selected lane size. For example, the 16-bit control lane 0x0100 is positive and 0x00FF is positive, whatever its byte halves hold.
- R6: Negating the most negative lane value (0x80, 0x8000, 0x80000000) yields that same value, with no saturation and no flag.
- R7: A valid operation whose `in_op` is outside 0x08..0x0A raises `out_illegal` for exactly the next cycle and leaves `out_result` unchanged.
- R8: `out_valid` equals `in_valid` delayed by one clock. `out_result` changes only after a cycle in which `in_valid` was high with a legal opcode.
- R9: With `in_reuse` high, the source operand is the current `out_result`. With it low, the source operand is `src_a`.
- R10: While `rst_n` is low, `out_valid`, `out_illegal` and `out_result` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 8 | Operation code selecting lane size |
| in_reuse | input | 1 | Take the source from the result register |
| src_a | input | VEC_W | Source vector |
| ctl_b | input | VEC_W | Control (sign) vector |
| out_valid | output | 1 | Result cycle marker, one clock after `in_valid` |
| out_illegal | output | 1 | Unknown opcode seen on the previous cycle |
| out_result | output | VEC_W | Registered result vector |

## Verification
The illegal-opcode path and the destructive reuse path can fall in the same cycle. In that case the result register is both the operand and the target that must stay untouched. The bench provokes this by issuing a valid illegal opcode with `in_reuse` high right after a legal result has been built. It then checks that `out_illegal` pulses and `out_result` holds its old value. A following legal reuse operation must then chain from that unchanged value. Every cycle is judged against a behavioural model that tracks the expected register contents.

// File: rtl/vsa_pkg.sv
package vsa_pkg;
  typedef enum logic [1:0] {
    LSZ_B8  = 2'd0,
    LSZ_W16 = 2'd1,
    LSZ_D32 = 2'd2,
    LSZ_BAD = 2'd3
  } lane_size_e;

  localparam logic [7:0] OP_BYTE  = 8'h08;
  localparam logic [7:0] OP_WORD  = 8'h09;
  localparam logic [7:0] OP_DWORD = 8'h0A;
  localparam int unsigned CHUNK_W = 32;
endpackage

// File: rtl/vsa_decode.sv
module vsa_decode
  import vsa_pkg::*;
(
  input  logic [7:0]  op,
  output lane_size_e  size,
  output logic        legal
);
  always_comb begin
    unique case (op)
      OP_BYTE:  size = LSZ_B8;
      OP_WORD:  size = LSZ_W16;
      OP_DWORD: size = LSZ_D32;
      default:  size = LSZ_BAD;
    endcase
    legal = (size != LSZ_BAD);
  end
endmodule

// File: rtl/vsa_sign_lane.sv
module vsa_sign_lane #(
  parameter int unsigned LW = 8
) (
  input  logic [LW-1:0] a,
  input  logic [LW-1:0] b,
  output logic [LW-1:0] y
);
  logic is_neg;
  logic is_zero;

  always_comb begin
    is_neg  = b[LW-1];
    is_zero = (b == '0);
    if (is_zero)     y = '0;
    else if (is_neg) y = (~a) + {{(LW-1){1'b0}}, 1'b1};
    else             y = a;
  end

  // R2: a zero control lane must never let source bits through
  always_comb begin
    if (b == '0) assert_zero_lane_R2: assert (y == '0);
  end
endmodule

// File: rtl/vsa_chunk.sv
module vsa_chunk
  import vsa_pkg::*;
(
  input  lane_size_e          size,
  input  logic [CHUNK_W-1:0]  a,
  input  logic [CHUNK_W-1:0]  b,
  output logic [CHUNK_W-1:0]  y
);
  localparam int unsigned NB = CHUNK_W / 8;
  localparam int unsigned NW = CHUNK_W / 16;
  localparam int unsigned ND = CHUNK_W / 32;

  logic [CHUNK_W-1:0] y_b8;
  logic [CHUNK_W-1:0] y_w16;
  logic [CHUNK_W-1:0] y_d32;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    vsa_sign_lane #(.LW(8)) u_lane (
      .a(a[i*8 +: 8]), .b(b[i*8 +: 8]), .y(y_b8[i*8 +: 8]));
  end
  for (genvar i = 0; i < NW; i++) begin : g_word
    vsa_sign_lane #(.LW(16)) u_lane (
      .a(a[i*16 +: 16]), .b(b[i*16 +: 16]), .y(y_w16[i*16 +: 16]));
  end
  for (genvar i = 0; i < ND; i++) begin : g_dword
    vsa_sign_lane #(.LW(32)) u_lane (
      .a(a[i*32 +: 32]), .b(b[i*32 +: 32]), .y(y_d32[i*32 +: 32]));
  end

  always_comb begin
    unique case (size)
      LSZ_B8:  y = y_b8;
      LSZ_W16: y = y_w16;
      LSZ_D32: y = y_d32;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/vec_sign_apply.sv
module vec_sign_apply
  import vsa_pkg::*;
#(
  parameter int unsigned VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_op,
  input  logic             in_reuse,
  input  logic [VEC_W-1:0] src_a,
  input  logic [VEC_W-1:0] ctl_b,
  output logic             out_valid,
  output logic             out_illegal,
  output logic [VEC_W-1:0] out_result
);
  localparam int unsigned NCHUNK = VEC_W / CHUNK_W;

  lane_size_e       size;
  logic             legal;
  logic [VEC_W-1:0] opnd_a;
  logic [VEC_W-1:0] lanes_y;

  logic             valid_q,   valid_d;
  logic             illegal_q, illegal_d;
  logic [VEC_W-1:0] result_q,  result_d;
  logic             result_en;
  logic             past_ok_q;

  vsa_decode u_decode (.op(in_op), .size(size), .legal(legal));

  assign opnd_a = in_reuse ? result_q : src_a;

  for (genvar c = 0; c < NCHUNK; c++) begin : g_chunk
    vsa_chunk u_chunk (
      .size(size),
      .a(opnd_a[c*CHUNK_W +: CHUNK_W]),
      .b(ctl_b[c*CHUNK_W +: CHUNK_W]),
      .y(lanes_y[c*CHUNK_W +: CHUNK_W]));
  end

  always_comb begin
    result_en = in_valid & legal;
    valid_d   = in_valid;
    illegal_d = in_valid & ~legal;
    result_d  = result_en ? lanes_y : result_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      illegal_q <= 1'b0;
      result_q  <= '0;
      past_ok_q <= 1'b0;
    end else begin
      valid_q   <= valid_d;
      illegal_q <= illegal_d;
      past_ok_q <= 1'b1;
      if (result_en) result_q <= result_d;
    end
  end

  assign out_valid   = valid_q;
  assign out_illegal = illegal_q;
  assign out_result  = result_q;

  assert_valid_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok_q |-> (out_valid == $past(in_valid)));
  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok_q && !$past(in_valid)) |-> $stable(out_result));
  assert_illegal_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok_q && out_illegal) |-> $stable(out_result));
  assert_illegal_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> out_valid);
endmodule

// File: tb/vec_sign_apply_tb.sv
`timescale 1ns/1ps
module vec_sign_apply_tb;
  localparam int W = 128;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [7:0]   in_op;
  logic         in_reuse;
  logic [W-1:0] src_a;
  logic [W-1:0] ctl_b;
  logic         out_valid;
  logic         out_illegal;
  logic [W-1:0] out_result;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  logic [W-1:0] m_result;

  always #2 clk = ~clk;

  vec_sign_apply #(.VEC_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_reuse(in_reuse), .src_a(src_a), .ctl_b(ctl_b),
    .out_valid(out_valid), .out_illegal(out_illegal), .out_result(out_result));

  function automatic logic [W-1:0] model(logic [W-1:0] a, logic [W-1:0] b, int lw);
    logic [W-1:0] r = '0;
    for (int i = 0; i < W / lw; i++) begin
      longint av = 0, bv = 0, rv;
      longint span = longint'(1) << lw;
      for (int j = 0; j < lw; j++) begin
        if (a[i*lw+j]) av += longint'(1) << j;
        if (b[i*lw+j]) bv += longint'(1) << j;
      end
      if (bv >= span / 2) bv -= span;
      if (bv < 0)       rv = (span - av) % span;
      else if (bv == 0) rv = 0;
      else              rv = av;
      for (int j = 0; j < lw; j++) r[i*lw+j] = rv[j];
    end
    return r;
  endfunction

  function automatic int op_width(logic [7:0] op);
    case (op)
      8'h08: return 8;
      8'h09: return 16;
      8'h0A: return 32;
      default: return 0;
    endcase
  endfunction

  function automatic logic [W-1:0] rnd_vec();
    logic [W-1:0] v;
    for (int k = 0; k < W / 32; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [W-1:0] fill(logic [31:0] pat, int lw);
    logic [W-1:0] v;
    for (int i = 0; i < W / lw; i++)
      for (int j = 0; j < lw; j++) v[i*lw+j] = pat[j];
    return v;
  endfunction

  task automatic cyc(bit v, logic [7:0] op, bit reuse, logic [W-1:0] a,
                     logic [W-1:0] b, string tag);
    bit e_ill;
    logic [W-1:0] e_res;
    in_valid = v; in_op = op; in_reuse = reuse; src_a = a; ctl_b = b;
    e_res = m_result;
    e_ill = v && (op_width(op) == 0);
    if (v && op_width(op) != 0)
      e_res = model(reuse ? m_result : a, b, op_width(op));
    @(negedge clk);
    m_result = e_res;
    tests++;
    if (out_valid !== v || out_illegal !== e_ill || out_result !== e_res) begin
      fails++;
      $display("FAIL %s: valid=%0b ill=%0b res=%h expected valid=%0b ill=%0b res=%h",
               tag, out_valid, out_illegal, out_result, v, e_ill, e_res);
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] ops [3];
    logic [31:0] dir [4];
    ops[0] = 8'h08; ops[1] = 8'h09; ops[2] = 8'h0A;
    rst_n = 1'b0; in_valid = 0; in_op = 0; in_reuse = 0; src_a = '0; ctl_b = '0;
    m_result = '0;
    repeat (3) @(negedge clk);
    tests++;
    if (out_valid !== 0 || out_illegal !== 0 || out_result !== '0) begin
      fails++;
      $display("FAIL R10 reset: valid=%0b ill=%0b res=%h expected 0 0 0",
               out_valid, out_illegal, out_result);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R4 R6: directed lanes 0, -1, min, max across every size
    for (int s = 0; s < 3; s++) begin
      int lw = op_width(ops[s]);
      logic [31:0] mx = (lw == 32) ? 32'h7FFFFFFF : ((32'h1 << (lw - 1)) - 1);
      logic [31:0] mn = (lw == 32) ? 32'h80000000 : (32'h1 << (lw - 1));
      dir[0] = 32'h0; dir[1] = 32'hFFFFFFFF; dir[2] = mn; dir[3] = mx;
      for (int x = 0; x < 4; x++)
        for (int y = 0; y < 4; y++)
          cyc(1, ops[s], 0, fill(dir[x], lw), fill(dir[y], lw), "R1/R2/R3/R6 directed");
    end

    // R6: most negative wraps to itself under a negative control
    cyc(1, 8'h08, 0, fill(32'h80, 8), fill(32'hFF, 8), "R6 byte wrap");
    cyc(1, 8'h0A, 0, fill(32'h80000000, 32), fill(32'h80000000, 32), "R6 dword wrap");

    // R5: full-lane tests, byte halves would judge differently
    cyc(1, 8'h09, 0, fill(32'h1234, 16), fill(32'h0100, 16), "R5 word low byte zero");
    cyc(1, 8'h09, 0, fill(32'h1234, 16), fill(32'h00FF, 16), "R5 word low byte negative");
    cyc(1, 8'h0A, 0, fill(32'hCAFE0001, 32), fill(32'h00000080, 32), "R5 dword positive");

    // R4: random vectors per size
    for (int s = 0; s < 3; s++)
      for (int n = 0; n < 200; n++)
        cyc(1, ops[s], 0, rnd_vec(), rnd_vec(), "R4 random");

    // R8: idle cycles hold result, valid follows
    cyc(0, 8'h08, 0, rnd_vec(), rnd_vec(), "R8 idle hold");
    cyc(0, 8'h09, 1, rnd_vec(), rnd_vec(), "R8 idle hold reuse");

    // R9: destructive chaining from the result register
    cyc(1, 8'h09, 0, rnd_vec(), fill(32'hFFFF, 16), "R9 seed");
    cyc(1, 8'h09, 1, rnd_vec(), fill(32'hFFFF, 16), "R9 reuse negate back");
    cyc(1, 8'h08, 1, '0, rnd_vec(), "R9 reuse random");

    // R7 with R9 in the same cycle: illegal op while reusing
    cyc(1, 8'h0B, 1, rnd_vec(), rnd_vec(), "R7 illegal with reuse");
    cyc(1, 8'h0A, 1, rnd_vec(), fill(32'hFFFFFFFF, 32), "R7 R9 chain after illegal");
    cyc(1, 8'h07, 0, rnd_vec(), rnd_vec(), "R7 illegal low");
    cyc(1, 8'hFF, 0, rnd_vec(), rnd_vec(), "R7 illegal high");
    cyc(0, 8'h00, 0, rnd_vec(), rnd_vec(), "R7 pulse ends");

    // mixed random traffic
    for (int n = 0; n < 300; n++) begin
      logic [7:0] op = ($urandom % 8 == 0) ? 8'(($urandom % 16) + 8'h02) : ops[$urandom % 3];
      cyc(($urandom % 4) != 0, op, ($urandom % 3) == 0, rnd_vec(), rnd_vec(), "R4/R7/R8/R9 mixed");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule